// File: doc/BRIEF.md
# Time-Slot Interchange Switch Core

This block is a compact, non-blocking time-division-multiplexed channel switch. Each serial input stream is gathered into bytes, one per channel. Each byte is stored in a per-stream data memory that holds two frames and is selected by frame parity. For every output stream, a connection memory names the source stream and the source channel for each output time slot. A shift register then sends the selected byte out serially, most significant bit first.

Every stream, input or output, picks one of four rates on its own. Each rate step doubles the bit clock, so a stream carries 32, 64, 128 or 256 channels per frame. Rates are converted through the data memory.

Each output slot chooses one of two delay behaviours:
- **Frame-preserving:** always take the byte from the previous frame.
- **Low-latency:** take the byte already written in the current frame, or fall back to the previous frame when the source slot has not yet completed.

A per-slot enable controls the output. A disabled slot sends ones. In backplane mode it also releases its drive enable, and a subset of output streams export a drive-off strobe for external buffers.

The system clock runs one tick per bit at the fastest rate, so a frame lasts `MAX_CH*8` clocks. A host writes connection words through an address, data and write-strobe port.

Top module: `tsi_switch`

## Requirements
- R1: `fp_o` is high in the first clock of every frame and low in the other `MAX_CH*8-1` clocks. The first frame starts in the clock in which reset is released.
- R2: Input stream i, with rate code r from `in_rate_i[2i+1:2i]` (0 slowest, 3 fastest), holds each bit for 2^(3-r) clocks and carries MAX_CH>>(3-r) channels, MSB first. Channel 0 starts in frame clock 0.
- R3: On an output stream of rate code r, bit b of channel k is presented in frame clocks (8k+b)*2^(3-r)+1 through (8k+b+1)*2^(3-r). The output frame thus trails the input frame by one clock.
- R4: Any output slot may take any input slot, and any number of output slots may take the same input slot.
- R5: A slot in frame-preserving mode outputs the source byte received in the previous frame.
- R6: A low-latency slot outputs the current frame's source byte when that source channel's last bit clock lies before the output slot's first load clock (k*8*2^(3-r_out)). Otherwise it outputs the previous frame's byte.
- R7: Input and output rates of a connection may differ, and R5 and R6 still hold.
- R8: A slot whose enable bit is clear outputs all ones.
- R9: With `bidir_i[j]` clear, `ser_oe_o[j]` stays high. With it set, `ser_oe_o[j]` is high exactly during enabled slots.
- R10: For output streams j < N_HZ, `hz_o[j]` is high exactly during disabled slots.
- R11: The host writes a connection word when `cm_we_i` is high.
  - Address: `{output stream, output channel}`, channel in the low CH_W bits.
  - Word bit 11: enable. Bit 10: low-latency mode. Bits 9:8: source stream. Bits 7:0: source channel.
- R12: After reset, all connection words are cleared, and all outputs send ones with every slot disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock, one tick per fastest-rate bit |
| rst_n | input | 1 | synchronous active-low reset |
| in_rate_i | input | 2*N_IN | per input stream rate code |
| out_rate_i | input | 2*N_OUT | per output stream rate code |
| bidir_i | input | N_OUT | per output stream backplane mode |
| ser_in_i | input | N_IN | serial input streams |
| ser_out_o | output | N_OUT | serial output streams |
| ser_oe_o | output | N_OUT | per output stream drive enable |
| hz_o | output | N_HZ | drive-off strobe for the first N_HZ output streams |
| fp_o | output | 1 | frame start marker |
| cm_we_i | input | 1 | connection memory write strobe |
| cm_addr_i | input | O_W+CH_W | connection memory address {stream, channel} |
| cm_wdata_i | input | 2+S_W+CH_W | connection memory word |

## Verification
Two events can meet in one cycle:
- **Write then read on adjacent edges.** An input byte lands in the data memory on the edge just before an output lane reads that same location for a low-latency slot. The bench programs directed slots whose source completes exactly one clock before the load, which must yield the current byte. It also programs slots whose source completes later, which must yield the previous frame's byte.
- **Frame wrap.** The last input byte of a frame is written on the same edge that swaps the banks. Frame-preserving slots that take the last channel check that this write reached the bank being read next.

Every serial bit is compared against a bench model that uses only the rates, the programmed words and the bytes that were sent.

// File: rtl/tsi_pkg.sv
// Shared definitions for the time-slot interchange switch.
// Rate codes step by a factor of two; code 3 is one bit per clock.
package tsi_pkg;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } rate_e;

    localparam int unsigned RATE_STEPS = 4;

    // Number of doublings between a rate and the fastest rate.
    function automatic logic [1:0] slow_shift(input logic [1:0] code);
        return 2'(RATE_STEPS - 1) - code;
    endfunction

endpackage

// File: rtl/tsi_frame_timer.sv
// Frame timer: counts clocks within one frame and tracks frame parity.
// Assumes a frame of FRAME_CLKS clocks, a power of two.
module tsi_frame_timer #(
    parameter int unsigned FRAME_CLKS = 2048,
    parameter int unsigned T_W        = $clog2(FRAME_CLKS)
) (
    input  logic           clk,
    input  logic           rst_n,
    output logic [T_W-1:0] slot_t,
    output logic           par,
    output logic           fp
);

    // Advance the frame clock; flip parity at each wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_t <= '0;
            par    <= 1'b0;
        end else if (slot_t == T_W'(FRAME_CLKS - 1)) begin
            slot_t <= '0;
            par    <= ~par;
        end else begin
            slot_t <= slot_t + 1'b1;
        end
    end

    // Mark the first clock of the frame.
    assign fp = (slot_t == '0);

endmodule

// File: rtl/tsi_rx_lane.sv
// Receive lane: deserialises one input stream and stores each finished
// byte into a two-bank data memory (bank = frame parity). It offers
// N_RD independent combinational read ports, one per output lane.
// Assumes MAX_CH is a power of two; the bit is sampled on the last
// clock of its bit period.
module tsi_rx_lane
    import tsi_pkg::*;
#(
    parameter int unsigned MAX_CH = 256,
    parameter int unsigned N_RD   = 4,
    parameter int unsigned T_W    = 11,
    parameter int unsigned CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate,
    input  logic [T_W-1:0]    slot_t,
    input  logic              par,
    input  logic              ser_in,
    input  logic [N_RD-1:0]   rd_bank,
    input  logic [N_RD*CH_W-1:0] rd_ch,
    output logic [N_RD*8-1:0] rd_data
);

    logic [7:0]      shreg;
    logic [7:0]      mem [2*MAX_CH];
    logic [1:0]      sh;
    logic [T_W-1:0]  bit_mask;
    logic [T_W-1:0]  chan_mask;
    logic            bit_end;
    logic            chan_end;
    logic [CH_W-1:0] wr_ch;

    // Decode bit and channel boundaries for this lane's rate.
    always_comb begin
        sh        = slow_shift(rate);
        bit_mask  = T_W'((1 << sh) - 1);
        chan_mask = T_W'((8 << sh) - 1);
        bit_end   = (slot_t & bit_mask) == bit_mask;
        chan_end  = (slot_t & chan_mask) == chan_mask;
        wr_ch     = CH_W'(slot_t >> (3 + sh));
    end

    // Shift in one bit per bit period, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
        end else if (bit_end) begin
            shreg <= {shreg[6:0], ser_in};
        end
    end

    // Commit the finished byte into the current frame's bank.
    always_ff @(posedge clk) begin
        if (rst_n && chan_end) begin
            mem[{par, wr_ch}] <= {shreg[6:0], ser_in};
        end
    end

    // One read port per output lane.
    for (genvar g = 0; g < N_RD; g++) begin : g_rd
        assign rd_data[g*8 +: 8] = mem[{rd_bank[g], rd_ch[g*CH_W +: CH_W]}];
    end

endmodule

// File: rtl/tsi_tx_lane.sv
// Transmit lane: owns the connection memory of one output stream,
// picks the source byte and bank at each slot start, and serialises
// it MSB first. Bits appear one clock after the slot's load clock.
// Assumes N_IN is a power of two so every source code is a real stream.
module tsi_tx_lane
    import tsi_pkg::*;
#(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned MAX_CH = 256,
    parameter int unsigned T_W    = 11,
    parameter int unsigned CH_W   = 8,
    parameter int unsigned S_W    = 2,
    parameter int unsigned CM_W   = 2 + S_W + CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate,
    input  logic [2*N_IN-1:0] in_rate_all,
    input  logic [T_W-1:0]   slot_t,
    input  logic             par,
    input  logic             cm_we,
    input  logic [CH_W-1:0]  cm_ch,
    input  logic [CM_W-1:0]  cm_wdata,
    output logic             rd_bank,
    output logic [CH_W-1:0]  rd_ch,
    output logic [S_W-1:0]   rd_src,
    input  logic [7:0]       rd_byte,
    output logic             ser_out,
    output logic             chan_en
);

    localparam int unsigned DW = CH_W + 7;

    logic [CM_W-1:0] cm [MAX_CH];
    logic [7:0]      osr;
    logic [1:0]      sh;
    logic [1:0]      src_rate;
    logic [T_W-1:0]  bit_mask;
    logic [T_W-1:0]  chan_mask;
    logic            load;
    logic            shift_now;
    logic [CH_W-1:0] out_ch;
    logic [CM_W-1:0] word;
    logic            w_en;
    logic            w_low_lat;
    logic [DW-1:0]   done_at;

    // Host writes and reset clearing of the connection memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(MAX_CH); i++) cm[i] <= '0;
        end else if (cm_we) begin
            cm[cm_ch] <= cm_wdata;
        end
    end

    // Slot timing, word fetch and bank choice for the slot being loaded.
    always_comb begin
        sh        = slow_shift(rate);
        bit_mask  = T_W'((1 << sh) - 1);
        chan_mask = T_W'((8 << sh) - 1);
        load      = (slot_t & chan_mask) == '0;
        shift_now = (slot_t & bit_mask) == '0;
        out_ch    = CH_W'(slot_t >> (3 + sh));
        word      = cm[out_ch];
        w_en      = word[CM_W-1];
        w_low_lat = word[CM_W-2];
        rd_src    = word[CH_W +: S_W];
        rd_ch     = word[CH_W-1:0];
        src_rate  = '0;
        for (int i = 0; i < int'(N_IN); i++) begin
            if (rd_src == S_W'(i)) src_rate = in_rate_all[2*i +: 2];
        end
        done_at   = ((DW'(rd_ch) + DW'(1)) << (3 + slow_shift(src_rate))) - DW'(1);
        rd_bank   = (w_low_lat && (done_at < DW'(slot_t))) ? par : ~par;
    end

    // Load a byte at slot start, otherwise shift at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osr     <= 8'hFF;
            chan_en <= 1'b0;
        end else if (load) begin
            osr     <= w_en ? rd_byte : 8'hFF;
            chan_en <= w_en;
        end else if (shift_now) begin
            osr <= {osr[6:0], 1'b1};
        end
    end

    assign ser_out = osr[7];

endmodule

// File: rtl/tsi_switch.sv
// Time-slot interchange switch top: frame timer, one receive lane per
// input stream, one transmit lane per output stream, and the crossbar of
// read ports between them. Assumes N_IN, N_OUT and MAX_CH are powers of
// two and that rates change only at frame boundaries.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int unsigned N_IN   = 4,
    parameter int unsigned N_OUT  = 4,
    parameter int unsigned N_HZ   = 2,
    parameter int unsigned MAX_CH = 256,
    parameter int unsigned CH_W   = $clog2(MAX_CH),
    parameter int unsigned S_W    = (N_IN > 1) ? $clog2(N_IN) : 1,
    parameter int unsigned O_W    = (N_OUT > 1) ? $clog2(N_OUT) : 1,
    parameter int unsigned CM_W   = 2 + S_W + CH_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*N_IN-1:0]   in_rate_i,
    input  logic [2*N_OUT-1:0]  out_rate_i,
    input  logic [N_OUT-1:0]    bidir_i,
    input  logic [N_IN-1:0]     ser_in_i,
    output logic [N_OUT-1:0]    ser_out_o,
    output logic [N_OUT-1:0]    ser_oe_o,
    output logic [N_HZ-1:0]     hz_o,
    output logic                fp_o,
    input  logic                cm_we_i,
    input  logic [O_W+CH_W-1:0] cm_addr_i,
    input  logic [CM_W-1:0]     cm_wdata_i
);

    localparam int unsigned FRAME_CLKS = MAX_CH * 8;
    localparam int unsigned T_W        = $clog2(FRAME_CLKS);

    logic [T_W-1:0]         slot_t;
    logic                   par;
    logic [N_OUT-1:0]       tx_bank;
    logic [N_OUT*CH_W-1:0]  tx_ch;
    logic [N_OUT*S_W-1:0]   tx_src;
    logic [N_OUT-1:0]       tx_en;
    logic [N_OUT*8-1:0]     rx_data [N_IN];

    tsi_frame_timer #(
        .FRAME_CLKS(FRAME_CLKS),
        .T_W       (T_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .slot_t(slot_t),
        .par   (par),
        .fp    (fp_o)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_rx
        tsi_rx_lane #(
            .MAX_CH(MAX_CH),
            .N_RD  (N_OUT),
            .T_W   (T_W),
            .CH_W  (CH_W)
        ) u_rx (
            .clk    (clk),
            .rst_n  (rst_n),
            .rate   (in_rate_i[2*i +: 2]),
            .slot_t (slot_t),
            .par    (par),
            .ser_in (ser_in_i[i]),
            .rd_bank(tx_bank),
            .rd_ch  (tx_ch),
            .rd_data(rx_data[i])
        );
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_tx
        logic       lane_we;
        logic [7:0] lane_byte;

        // Decode host writes for this lane and route its source byte.
        assign lane_we   = cm_we_i && (cm_addr_i[CH_W +: O_W] == O_W'(j));
        assign lane_byte = rx_data[tx_src[j*S_W +: S_W]][j*8 +: 8];

        tsi_tx_lane #(
            .N_IN  (N_IN),
            .MAX_CH(MAX_CH),
            .T_W   (T_W),
            .CH_W  (CH_W),
            .S_W   (S_W),
            .CM_W  (CM_W)
        ) u_tx (
            .clk        (clk),
            .rst_n      (rst_n),
            .rate       (out_rate_i[2*j +: 2]),
            .in_rate_all(in_rate_i),
            .slot_t     (slot_t),
            .par        (par),
            .cm_we      (lane_we),
            .cm_ch      (cm_addr_i[CH_W-1:0]),
            .cm_wdata   (cm_wdata_i),
            .rd_bank    (tx_bank[j]),
            .rd_ch      (tx_ch[j*CH_W +: CH_W]),
            .rd_src     (tx_src[j*S_W +: S_W]),
            .rd_byte    (lane_byte),
            .ser_out    (ser_out_o[j]),
            .chan_en    (tx_en[j])
        );

        // Drive enable follows the slot only in backplane mode.
        assign ser_oe_o[j] = bidir_i[j] ? tx_en[j] : 1'b1;
    end

    for (genvar k = 0; k < N_HZ; k++) begin : g_hz
        assign hz_o[k] = ~tx_en[k];
    end

endmodule

// File: rtl/tsi_switch_chk.sv
// Property checker for tsi_switch, attached with bind. It keeps its own
// frame counter to judge the frame marker.
module tsi_switch_chk #(
    parameter int unsigned N_OUT  = 4,
    parameter int unsigned N_HZ   = 2,
    parameter int unsigned MAX_CH = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_OUT-1:0] bidir_i,
    input logic [N_OUT-1:0] ser_out_o,
    input logic [N_OUT-1:0] ser_oe_o,
    input logic [N_HZ-1:0]  hz_o,
    input logic             fp_o
);

    localparam int unsigned FRAME_CLKS = MAX_CH * 8;
    localparam int unsigned T_W        = $clog2(FRAME_CLKS);

    logic [T_W-1:0] frm_cnt;

    // Independent count of clocks since the frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) frm_cnt <= '0;
        else        frm_cnt <= frm_cnt + 1'b1;
    end

    a_r1_frame_mark: assert property (@(posedge clk) disable iff (!rst_n)
        fp_o == (frm_cnt == '0));

    a_r12_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ser_out_o == '1 && hz_o == '1));

    for (genvar j = 0; j < N_OUT; j++) begin : g_oe
        a_r9_oe_unidir: assert property (@(posedge clk) disable iff (!rst_n)
            !bidir_i[j] |-> ser_oe_o[j]);
    end

    for (genvar k = 0; k < N_HZ; k++) begin : g_hzc
        a_r8_idle_ones: assert property (@(posedge clk) disable iff (!rst_n)
            hz_o[k] |-> ser_out_o[k]);
        a_r10_hz_vs_oe: assert property (@(posedge clk) disable iff (!rst_n)
            bidir_i[k] |-> (hz_o[k] != ser_oe_o[k]));
    end

endmodule

bind tsi_switch tsi_switch_chk #(
    .N_OUT (N_OUT),
    .N_HZ  (N_HZ),
    .MAX_CH(MAX_CH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bidir_i  (bidir_i),
    .ser_out_o(ser_out_o),
    .ser_oe_o (ser_oe_o),
    .hz_o     (hz_o),
    .fp_o     (fp_o)
);

// File: tb/tsi_switch_test.sv
// Bench for tsi_switch: random frames and connection maps per phase,
// plus directed slot pairs around the low-latency decision point.
module tsi_switch_test;

    localparam int NI = 4;
    localparam int NO = 4;
    localparam int NH = 2;
    localparam int FR = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  in_rate_i = '0;
    logic [7:0]  out_rate_i = '0;
    logic [3:0]  bidir_i = '0;
    logic [3:0]  ser_in_i = '0;
    logic [3:0]  ser_out_o;
    logic [3:0]  ser_oe_o;
    logic [1:0]  hz_o;
    logic        fp_o;
    logic        cm_we_i = 1'b0;
    logic [9:0]  cm_addr_i = '0;
    logic [11:0] cm_wdata_i = '0;

    int tests = 0;
    int fails = 0;

    logic [7:0]  bd [2][NI][256];
    logic [11:0] cm_tab [NO][256];
    logic [1:0]  rin [NI];
    logic [1:0]  rout [NO];
    logic [3:0]  bidir_n;
    int          fpar = 1;

    always #4 clk = ~clk;

    tsi_switch uut (
        .clk(clk), .rst_n(rst_n), .in_rate_i(in_rate_i), .out_rate_i(out_rate_i),
        .bidir_i(bidir_i), .ser_in_i(ser_in_i), .ser_out_o(ser_out_o),
        .ser_oe_o(ser_oe_o), .hz_o(hz_o), .fp_o(fp_o), .cm_we_i(cm_we_i),
        .cm_addr_i(cm_addr_i), .cm_wdata_i(cm_wdata_i)
    );

    task automatic check(input string tag, input int got, input int exp, input int j, input int t);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s stream %0d t=%0d got %0d expected %0d", tag, j, t, got, exp);
        end
    endtask

    // Expected serial bit and slot enable for output j in frame clock t.
    task automatic expect_out(input int j, input int t, output int eb, output int een);
        int po, lo, bp, k, b, li, c, src, sch;
        logic [11:0] w;
        logic cur;
        po = 1 << (3 - rout[j]);
        lo = 8 * po;
        bp = (t - 1) / po;
        k = bp / 8;
        b = bp % 8;
        w = cm_tab[j][k];
        een = int'(w[11]);
        if (!w[11]) begin
            eb = 1;
        end else begin
            src = int'(w[9:8]);
            sch = int'(w[7:0]);
            li  = 8 << (3 - rin[src]);
            c   = (sch + 1) * li - 1;
            cur = w[10] && (c < k * lo);
            eb  = int'(bd[cur ? fpar : 1 - fpar][src][sch][7 - b]);
        end
    endtask

    function automatic logic [11:0] rand_word(input int en_pct, input int ll_pct);
        int src;
        int sch;
        src = int'($urandom % NI);
        sch = int'($urandom % (32 << rin[src]));
        return {($urandom % 100) < en_pct, ($urandom % 100) < ll_pct, 2'(src), 8'(sch)};
    endfunction

    // One frame: refresh data, optionally apply config, drive and check.
    task automatic run_frame(input bit chk, input bit cfg, input string tag);
        int eb, een, pi, bp;
        for (int t = 0; t < FR; t++) begin
            if (t == 0) begin
                fpar = 1 - fpar;
                for (int i = 0; i < NI; i++)
                    for (int c = 0; c < 256; c++) bd[fpar][i][c] = 8'($urandom);
                if (cfg) begin
                    for (int i = 0; i < NI; i++) in_rate_i[2*i +: 2] = rin[i];
                    for (int j = 0; j < NO; j++) out_rate_i[2*j +: 2] = rout[j];
                    bidir_i = bidir_n;
                end
            end
            if (t < 2) check("R1 frame mark", int'(fp_o), (t == 0) ? 1 : 0, 0, t);
            for (int i = 0; i < NI; i++) begin
                pi = 1 << (3 - rin[i]);
                bp = t / pi;
                ser_in_i[i] = bd[fpar][i][bp / 8][7 - (bp % 8)];
            end
            if (cfg && t < 1024) begin
                cm_we_i    = 1'b1;
                cm_addr_i  = 10'(t);
                cm_wdata_i = cm_tab[t / 256][t % 256];
            end else begin
                cm_we_i = 1'b0;
            end
            if (chk && t >= 1) begin
                for (int j = 0; j < NO; j++) begin
                    expect_out(j, t, eb, een);
                    check(een != 0 ? {tag, " R2 R3 R11"} : "R8 idle", int'(ser_out_o[j]), eb, j, t);
                    check(bidir_i[j] ? "R9 oe backplane" : "R9 oe driven", int'(ser_oe_o[j]),
                          bidir_i[j] ? een : 1, j, t);
                    if (j < NH) check("R10 hz", int'(hz_o[j]), een != 0 ? 0 : 1, j, t);
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic phase(input string tag);
        run_frame(1'b0, 1'b1, tag);
        run_frame(1'b1, 1'b0, tag);
        run_frame(1'b1, 1'b0, tag);
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NI; i++) rin[i] = 2'd3;
        for (int j = 0; j < NO; j++) rout[j] = 2'd3;
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++) cm_tab[j][k] = '0;
        bidir_n = '0;
        repeat (5) @(negedge clk);
        // R12: state held in reset
        check("R12 reset out", int'(ser_out_o), 15, 0, 0);
        check("R12 reset hz", int'(hz_o), 3, 0, 0);
        check("R12 reset oe", int'(ser_oe_o), 15, 0, 0);
        rst_n = 1'b1;
        run_frame(1'b1, 1'b0, "R12");

        // R5: fastest rates, frame-preserving
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++) cm_tab[j][k] = rand_word(100, 0);
        phase("R5");

        // R6: low latency, directed slots around the completion point
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++) begin
            if (j == 0)      cm_tab[j][k] = {2'b11, 2'd1, 8'((k + 255) % 256)};
            else if (j == 1) cm_tab[j][k] = {2'b11, 2'd2, 8'(k)};
            else             cm_tab[j][k] = rand_word(100, 100);
        end
        phase("R6");

        // R4: every slot takes the same source, mixed rates
        for (int i = 0; i < NI; i++) rin[i] = 2'($urandom);
        for (int j = 0; j < NO; j++) rout[j] = 2'($urandom);
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++)
            cm_tab[j][k] = {1'b1, 1'($urandom), 2'd2, 8'(5 % (32 << rin[2]))};
        phase("R4");

        // R7: slow inputs, fast outputs
        for (int i = 0; i < NI; i++) rin[i] = 2'($urandom % 2);
        for (int j = 0; j < NO; j++) rout[j] = 2'(2 + $urandom % 2);
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++) cm_tab[j][k] = rand_word(100, 50);
        phase("R7");

        // R8 R9 R10: fast inputs, slow outputs, sparse enables, backplane mix
        for (int i = 0; i < NI; i++) rin[i] = 2'(2 + $urandom % 2);
        for (int j = 0; j < NO; j++) rout[j] = 2'($urandom % 2);
        bidir_n = 4'b0101;
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++) cm_tab[j][k] = rand_word(50, 50);
        phase("R8");

        // R2 R3 R7: everything random
        for (int i = 0; i < NI; i++) rin[i] = 2'($urandom);
        for (int j = 0; j < NO; j++) rout[j] = 2'($urandom);
        bidir_n = 4'($urandom);
        for (int j = 0; j < NO; j++) for (int k = 0; k < 256; k++) cm_tab[j][k] = rand_word(80, 50);
        phase("R7");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule